// File: doc/BRIEF.md
# Streaming Word Source with Ready-Latency Control

This block puts single data words onto a valid/ready stream. A word enters through a small command port together with a gap count. The gap count is the number of idle cycles, with valid low, that the block inserts before it starts to offer that word. Once the gap has run out, the block offers the word to the sink. How it does this depends on the compile-time ready latency `RL`. With `RL = 0` it raises valid, keeps the word on the bus and waits for ready. With `RL > 0` it keeps valid low until ready was high `RL` cycles earlier, and then sends the word in that cycle.

The control is a three-state machine:
- `ST_EMPTY` waits for a command and is the only state in which `cmd_ready` is high.
- `ST_GAP` counts down the idle cycles.
- `ST_DRIVE` offers the word until it is transferred.

The transitions are:
- EMPTY to GAP when a command with a non-zero gap is taken.
- EMPTY to DRIVE when a command with a zero gap is taken.
- GAP to DRIVE on the last idle cycle.
- DRIVE to EMPTY in the transfer cycle.

Four registered single-cycle pulses report:
- the first valid cycle of a transaction;
- ready rising;
- ready falling;
- completion.

A registered latency output holds the number of cycles from the first drive-phase cycle to the transfer cycle, both included.

Top module: `stream_source`

## Requirements
- R1: With RL = 0, from the first drive-phase cycle `src_valid` stays high and `src_data` equals the commanded word until the first cycle in which `snk_ready` is high. The transfer happens in that cycle, and `src_valid` is low in the next cycle.
- R2: With RL > 0, `src_valid` is high in a drive-phase cycle t exactly when `snk_ready` was high in cycle t−RL. That cycle is the transfer, it carries the commanded word, and `src_valid` is never high in any other cycle.
- R3: A command taken in cycle t with gap count g (`cmd_valid` and `cmd_ready` both high in t) starts its drive phase in cycle t+g+1. `src_valid` stays low from t+1 to t+g.
- R4: `cmd_ready` is high exactly when no transaction is held, and it rises in the cycle after a transfer. A command offered while `cmd_ready` is low has no effect on the word that is sent.
- R5: `ev_drive` is high for exactly one cycle, in the cycle after the first cycle in which a transaction has `src_valid` high.
- R6: `ev_ready_rise` is high in cycle t+1 exactly when `snk_ready` was high in t and low in t−1. `ev_ready_fall` is high in cycle t+1 exactly when `snk_ready` was low in t and high in t−1. A cycle before reset release counts as low.
- R7: `ev_done` is high for one cycle, in the cycle after a transfer. In that same cycle `lat_cycles` becomes the transfer cycle minus the first drive-phase cycle plus one, and it holds that value until the next completion.
- R8: After synchronous active-high reset, `src_valid`, all event pulses and `lat_cycles` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_data | input | DW | Word to send |
| cmd_idles | input | IW | Idle cycles before the word |
| snk_ready | input | 1 | Sink ready |
| src_valid | output | 1 | Stream valid |
| src_data | output | DW | Stream word |
| ev_drive | output | 1 | Pulse: first valid cycle of a transaction seen |
| ev_ready_rise | output | 1 | Pulse: ready went high |
| ev_ready_fall | output | 1 | Pulse: ready went low |
| ev_done | output | 1 | Pulse: transaction transferred |
| lat_cycles | output | LW | Latency of the last transaction |

## Verification
Both RL = 0 and RL = 2 instances are run. Each receives four ready patterns:
- **Ready always high, with zero gaps.** This isolates the gap timing and the back-to-back command turnaround.
- **Ready mostly low.** This stretches the RL = 0 hold and separates it from the RL > 0 idling, where valid must track ready from RL cycles earlier.
- **A long forced stall.** This drives large latency values.
- **Random toggling.** This exercises the rise and fall pulses and distinguishes a correct latency window from one that is off by a cycle.

Commands are also offered while the block is busy, to show that they are ignored.

// File: rtl/stsrc_pkg.sv
package stsrc_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_GAP,
        ST_DRIVE
    } stsrc_state_e;
endpackage

// File: rtl/stsrc_ready_window.sv
module stsrc_ready_window #(
    parameter int RL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_i,
    output logic allow_o,
    output logic xfer_ok_o
);
    generate
        if (RL == 0) begin : g_direct
            assign allow_o   = 1'b1;
            assign xfer_ok_o = ready_i;
        end else begin : g_delayed
            logic [RL-1:0] hist;
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= (hist << 1) | RL'(ready_i);
            end
            assign allow_o   = hist[RL-1];
            assign xfer_ok_o = hist[RL-1];
        end
    endgenerate
endmodule

// File: rtl/stsrc_gap_counter.sv
module stsrc_gap_counter #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [IW-1:0] load_val_i,
    input  logic          step_i,
    output logic          last_o
);
    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (load_i) cnt <= load_val_i;
        else if (step_i && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign last_o = (cnt == IW'(1));
endmodule

// File: rtl/stsrc_lat_counter.sv
module stsrc_lat_counter #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          run_i,
    input  logic          capture_i,
    output logic [LW-1:0] value_o
);
    logic [LW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            value_o <= '0;
        end else begin
            if (start_i)
                run_cnt <= LW'(1);
            else if (run_i && run_cnt != '1)
                run_cnt <= run_cnt + 1'b1;
            if (capture_i)
                value_o <= run_cnt;
        end
    end
endmodule

// File: rtl/stream_source.sv
module stream_source
    import stsrc_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 4,
    parameter int LW = 8,
    parameter int RL = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [DW-1:0] cmd_data,
    input  logic [IW-1:0] cmd_idles,
    input  logic          snk_ready,
    output logic          src_valid,
    output logic [DW-1:0] src_data,
    output logic          ev_drive,
    output logic          ev_ready_rise,
    output logic          ev_ready_fall,
    output logic          ev_done,
    output logic [LW-1:0] lat_cycles
);
    stsrc_state_e state, state_nx;
    logic [DW-1:0] word_q;
    logic          allow, xfer_ok, gap_last;
    logic          cmd_take, beat_done, enter_drive;
    logic          rdy_q, drove_q;

    assign cmd_ready   = (state == ST_EMPTY);
    assign cmd_take    = cmd_valid && cmd_ready;
    assign src_valid   = (state == ST_DRIVE) && allow;
    assign beat_done   = src_valid && xfer_ok;
    assign enter_drive = (state_nx == ST_DRIVE) && (state != ST_DRIVE);
    assign src_data    = word_q;

    stsrc_ready_window #(.RL(RL)) u_window (
        .clk       (clk),
        .rst       (rst),
        .ready_i   (snk_ready),
        .allow_o   (allow),
        .xfer_ok_o (xfer_ok)
    );

    stsrc_gap_counter #(.IW(IW)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cmd_take),
        .load_val_i (cmd_idles),
        .step_i     (state == ST_GAP),
        .last_o     (gap_last)
    );

    stsrc_lat_counter #(.LW(LW)) u_lat (
        .clk       (clk),
        .rst       (rst),
        .start_i   (enter_drive),
        .run_i     ((state == ST_DRIVE) && !beat_done),
        .capture_i (beat_done),
        .value_o   (lat_cycles)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (cmd_take)  state_nx = (cmd_idles == '0) ? ST_DRIVE : ST_GAP;
            ST_GAP:   if (gap_last)  state_nx = ST_DRIVE;
            ST_DRIVE: if (beat_done) state_nx = ST_EMPTY;
            default:                 state_nx = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    // registered outputs and event pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q        <= '0;
            rdy_q         <= 1'b0;
            drove_q       <= 1'b0;
            ev_drive      <= 1'b0;
            ev_ready_rise <= 1'b0;
            ev_ready_fall <= 1'b0;
            ev_done       <= 1'b0;
        end else begin
            if (cmd_take) word_q <= cmd_data;
            rdy_q         <= snk_ready;
            ev_ready_rise <= snk_ready && !rdy_q;
            ev_ready_fall <= !snk_ready && rdy_q;
            ev_drive      <= src_valid && !drove_q;
            ev_done       <= beat_done;
            if (beat_done)      drove_q <= 1'b0;
            else if (src_valid) drove_q <= 1'b1;
        end
    end
endmodule

// File: rtl/stream_source_chk.sv
module stream_source_chk #(
    parameter int DW = 16,
    parameter int RL = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          snk_ready,
    input logic          src_valid,
    input logic [DW-1:0] src_data,
    input logic          ev_drive,
    input logic          ev_ready_rise,
    input logic          ev_ready_fall,
    input logic          ev_done
);
    generate
        if (RL == 0) begin : g_hold
            assert_hold_word_R1: assert property (@(posedge clk) disable iff (rst)
                src_valid && !snk_ready |=> src_valid && $stable(src_data));
        end else begin : g_window
            logic [RL-1:0] seen;
            always_ff @(posedge clk) begin
                if (rst) seen <= '0;
                else     seen <= (seen << 1) | RL'(snk_ready);
            end
            assert_valid_window_R2: assert property (@(posedge clk) disable iff (rst)
                src_valid |-> seen[RL-1]);
        end
    endgenerate

    assert_busy_blocks_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        src_valid |-> !cmd_ready);

    assert_take_closes_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    assert_drive_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        ev_drive |-> $past(src_valid) && $stable(src_data));

    assert_rise_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(snk_ready) |=> ev_ready_rise);

    assert_fall_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(snk_ready) |=> ev_ready_fall);

    assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> cmd_ready && !src_valid);
endmodule

bind stream_source stream_source_chk #(.DW(DW), .RL(RL)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .snk_ready     (snk_ready),
    .src_valid     (src_valid),
    .src_data      (src_data),
    .ev_drive      (ev_drive),
    .ev_ready_rise (ev_ready_rise),
    .ev_ready_fall (ev_ready_fall),
    .ev_done       (ev_done)
);

// File: tb/stream_source_test.sv
`timescale 1ns/1ps

module stream_source_lane #(
    parameter int RL   = 2,
    parameter int SEED = 1
) (
    input  logic clk,
    input  logic rst,
    output logic finished,
    output int   n_chk,
    output int   n_fail
);
    localparam int DW = 16;
    localparam int IW = 4;
    localparam int LW = 8;
    localparam int RI = (RL == 0) ? 0 : RL - 1;
    localparam int NCYC = 1200;

    logic          cmd_valid, cmd_ready, snk_ready, src_valid;
    logic [DW-1:0] cmd_data, src_data;
    logic [IW-1:0] cmd_idles;
    logic          ev_drive, ev_ready_rise, ev_ready_fall, ev_done;
    logic [LW-1:0] lat_cycles;

    stream_source #(.DW(DW), .IW(IW), .LW(LW), .RL(RL)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_idles(cmd_idles),
        .snk_ready(snk_ready),
        .src_valid(src_valid), .src_data(src_data),
        .ev_drive(ev_drive), .ev_ready_rise(ev_ready_rise),
        .ev_ready_fall(ev_ready_fall), .ev_done(ev_done),
        .lat_cycles(lat_cycles)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s RL=%0d %s actual=%0d expected=%0d", req, RL, what, act, exp);
        end
    endtask

    function automatic bit pick_ready(input int n);
        if (n < 150)      return 1'b1;
        else if (n < 300) return ($urandom_range(0, 7) == 0);
        else if (n < 322) return 1'b0;
        else              return $urandom_range(0, 1) == 1;
    endfunction

    function automatic int pick_idles(input int n);
        if (n < 150)                      return 0;
        else if ($urandom_range(0, 9) == 0) return 15;
        else                              return $urandom_range(0, 3);
    endfunction

    initial begin
        bit [7:0]      rh;
        bit            act, got, done_prev, in_drive, exp_v, new_rdy;
        int            ds, ca, fv, last_lat;
        logic [DW-1:0] word;
        string         tag;
        void'($urandom(SEED));
        n_chk = 0; n_fail = 0; finished = 0;
        cmd_valid = 0; cmd_data = '0; cmd_idles = '0; snk_ready = 0;
        rh = '0; act = 0; got = 0; ds = 0; ca = -10; fv = -10; last_lat = 0; word = '0;
        @(negedge clk);
        while (rst) @(negedge clk);
        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            if (n == 0) begin
                check(src_valid == 0, "R8", "reset src_valid", src_valid, 0);
                check(cmd_ready == 1, "R8", "reset cmd_ready", cmd_ready, 1);
                check(lat_cycles == 0, "R8", "reset lat_cycles", lat_cycles, 0);
                check({ev_drive, ev_done} == 0, "R8", "reset pulses", {ev_drive, ev_done}, 0);
            end
            done_prev = got;
            check(ev_done == done_prev, "R7", "ev_done", ev_done, done_prev);
            if (done_prev) begin
                last_lat = ca - ds + 1;
                act = 0; got = 0;
            end
            check(lat_cycles == LW'(last_lat), "R7", "lat_cycles", lat_cycles, last_lat);
            check(cmd_ready == !act, "R4", "cmd_ready", cmd_ready, !act);
            in_drive = act && !got && n >= ds;
            exp_v    = (RL == 0) ? in_drive : (in_drive && rh[RI]);
            if (act && n <= ds) tag = "R3";
            else if (RL == 0)   tag = "R1";
            else                tag = "R2";
            check(src_valid == exp_v, tag, "src_valid", src_valid, exp_v);
            if (exp_v)
                check(src_data == word, (RL == 0) ? "R1" : "R2", "src_data", src_data, word);
            check(ev_drive == (fv == n - 1), "R5", "ev_drive", ev_drive, fv == n - 1);
            check(ev_ready_rise == (rh[0] && !rh[1]), "R6", "ev_ready_rise",
                  ev_ready_rise, rh[0] && !rh[1]);
            check(ev_ready_fall == (!rh[0] && rh[1]), "R6", "ev_ready_fall",
                  ev_ready_fall, !rh[0] && rh[1]);

            // drive inputs for this cycle
            new_rdy   = pick_ready(n);
            snk_ready = new_rdy;
            if (exp_v && fv < ds) fv = n;
            if (in_drive && ((RL == 0) ? new_rdy : rh[RI])) begin
                got = 1; ca = n;
            end
            cmd_idles = IW'(pick_idles(n));
            cmd_data  = DW'($urandom);
            if (!act) begin
                cmd_valid = (n < 150) ? 1'b1 : ($urandom_range(0, 9) < 7);
                if (cmd_valid) begin
                    act = 1; word = cmd_data; ds = n + int'(cmd_idles) + 1;
                end
            end else begin
                cmd_valid = ($urandom_range(0, 1) == 1);  // ignored while busy (R4)
            end
            rh = {rh[6:0], new_rdy};
        end
        @(negedge clk);
        cmd_valid = 0;
        finished = 1;
    end
endmodule

module stream_source_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fin_a, fin_b;
    int   chk_a, chk_b, fail_a, fail_b;
    int   wd_fail;

    always #2.5 clk = ~clk;

    stream_source_lane #(.RL(2), .SEED(11)) lane_rl2 (
        .clk(clk), .rst(rst), .finished(fin_a), .n_chk(chk_a), .n_fail(fail_a));
    stream_source_lane #(.RL(0), .SEED(23)) lane_rl0 (
        .clk(clk), .rst(rst), .finished(fin_b), .n_chk(chk_b), .n_fail(fail_b));

    initial begin
        wd_fail = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        fork
            wait (fin_a === 1'b1 && fin_b === 1'b1);
            repeat (200000) @(posedge clk);
        join_any
        disable fork;
        if (!(fin_a === 1'b1 && fin_b === 1'b1)) begin
            wd_fail = 1;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", chk_a + chk_b + wd_fail,
                 fail_a + fail_b + wd_fail);
        $finish;
    end
endmodule